// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block runs single read or write transactions on a PHY's internal control-register port, which has no bus clock of its own. The port has a clock that the master pulses by hand, plus a select line, separate read and write enables, a 16-bit address, 16-bit write data, 16-bit read data and an acknowledge. A user request carries a direction, an address and write data. The block then runs a fixed sequence and reports the result with a one-cycle `done` pulse, a `timeout` flag and the captured read data.

The sequence is as follows. A warm-up of `PREAMBLE_PULSES` port-clock pulses comes first. Select is raised next, then the address and any write data are presented. The matching enable is raised, one port-clock pulse is given with the enable high, and the enable is dropped. Acknowledge is then polled. Each poll that finds acknowledge low is followed by one more port-clock pulse and a pause, and the access gives up after `MAX_POLLS` misses. Each high or low phase of the port clock lasts `PHASE_CLKS` system clocks. The pause lasts `CLKS_PER_US * POLL_WAIT_US` system clocks.

The sequencer has these states:

| State | Role |
|-------|------|
| ST_IDLE | Waits for a request. |
| ST_PRE_HI / ST_PRE_LO | Run the warm-up pulses. ST_PRE_LO returns to ST_PRE_HI until the last pulse, then moves to ST_SEL. |
| ST_SEL | Raises select. |
| ST_ADDR | Drives the address and write data. |
| ST_ARM | Raises the enable. |
| ST_GO_HI / ST_GO_LO | Give the start pulse, then lead to ST_POLL. |
| ST_POLL | Samples acknowledge. A hit goes to ST_FINISH and a miss goes to ST_RETRY_HI. |
| ST_RETRY_HI / ST_RETRY_LO / ST_PAUSE | Pulse the port clock and wait. ST_PAUSE returns to ST_POLL, or goes to ST_FINISH with the failure mark after the last miss. |
| ST_FINISH | Pulses done and returns to ST_IDLE. |

Every state except ST_IDLE, ST_POLL and ST_FINISH lasts `PHASE_CLKS` cycles. ST_PAUSE is the exception and lasts the pause length.

Top module: `phy_creg_master`

## Requirements
- R1: While reset is held and after it is released, port_clk, port_sel, port_rd_en, port_wr_en, busy, done and timeout are all low. port_addr and port_wdata are zero while idle.
- R2: Each access begins with exactly PREAMBLE_PULSES port_clk pulses before port_sel rises. Each pulse is high for PHASE_CLKS system clocks and then low for PHASE_CLKS system clocks.
- R3: port_sel rises after the warm-up, while port_addr is still zero. The request address appears on port_addr in the phase after select. Select stays high until the access finishes.
- R4: For a write, port_wdata carries the request write data for at least one phase before port_wr_en rises.
- R5: port_rd_en (for a read) or port_wr_en (for a write) rises after the address phase. It stays high through exactly one port_clk pulse and then falls. The two enables are never high together.
- R6: After the start pulse, acknowledge is sampled for one cycle. Each miss adds one port_clk pulse and a pause of CLKS_PER_US*POLL_WAIT_US cycles before the next sample. If the ack is seen at sample k, done follows 205*PHASE_CLKS + k + (k-1)*(2*PHASE_CLKS+pause) cycles after the request is taken, after PREAMBLE_PULSES+k port_clk pulses in total.
- R7: If acknowledge is low on all MAX_POLLS samples, the access ends after the last miss pulse and pause. done and timeout are high together, and rdata keeps its previous value.
- R8: A read that sees acknowledge loads rdata with port_rdata from the sampling cycle. rdata changes at no other time.
- R9: busy is high from the cycle after a request is taken until done. Requests presented while busy are ignored.
- R10: done is a one-cycle pulse, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, taken only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| timeout | output | 1 | High with done when acknowledge never came |
| rdata | output | 16 | Last successfully read data |
| port_clk | output | 1 | Hand-pulsed port clock |
| port_sel | output | 1 | Port select |
| port_rd_en | output | 1 | Read enable |
| port_wr_en | output | 1 | Write enable |
| port_addr | output | 16 | Address to the port |
| port_wdata | output | 16 | Write data to the port |
| port_rdata | input | 16 | Read data from the port |
| port_ack | input | 1 | Port acknowledge |

## Verification
The assertions assume that the port holds port_rdata steady in the cycle it raises acknowledge. They also assume that no request arrives while reset is held. They rely on the port driving acknowledge only after the enables have dropped, so the start pulse never overlaps a sample. The bench models the port with a counter of port_clk pulses after the start. It raises acknowledge once k-1 miss pulses have passed, sweeps k over every sample position and one position past the limit for both directions, and derives read data from the address on the port.

// File: rtl/creg_pkg.sv
package creg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_SEL,
        ST_ADDR,
        ST_ARM,
        ST_GO_HI,
        ST_GO_LO,
        ST_POLL,
        ST_RETRY_HI,
        ST_RETRY_LO,
        ST_PAUSE,
        ST_FINISH
    } creg_state_e;
endpackage

// File: rtl/creg_phase_timer.sv
module creg_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/creg_event_counter.sv
module creg_event_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/phy_creg_master.sv
module phy_creg_master
    import creg_pkg::*;
#(
    parameter int PHASE_CLKS      = 4,
    parameter int PREAMBLE_PULSES = 100,
    parameter int MAX_POLLS       = 10,
    parameter int CLKS_PER_US     = 100,
    parameter int POLL_WAIT_US    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        timeout,
    output logic [15:0] rdata,
    output logic        port_clk,
    output logic        port_sel,
    output logic        port_rd_en,
    output logic        port_wr_en,
    output logic [15:0] port_addr,
    output logic [15:0] port_wdata,
    input  logic [15:0] port_rdata,
    input  logic        port_ack
);
    localparam int WAIT_CYC = CLKS_PER_US * POLL_WAIT_US;
    localparam int LEN_MAX  = (PHASE_CLKS > WAIT_CYC) ? PHASE_CLKS : WAIT_CYC;
    localparam int TMR_W    = $clog2(LEN_MAX + 1);

    creg_state_e state_q, state_d;

    logic        wr_q;
    logic        fail_q;
    logic [15:0] addr_q;
    logic [15:0] wdata_q;
    logic [15:0] rdata_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             pre_last;
    logic             poll_last;
    logic             accept;
    logic             pre_inc;
    logic             miss_inc;
    logic             drive_addr;
    logic             en_phase;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign pre_inc  = (state_q == ST_PRE_LO) && tmr_done;
    assign miss_inc = (state_q == ST_PAUSE) && tmr_done;

    // Length of each timed state, in cycles minus one
    function automatic logic [TMR_W-1:0] state_len(input creg_state_e s);
        unique case (s)
            ST_PAUSE:          state_len = TMR_W'(WAIT_CYC - 1);
            ST_POLL, ST_FINISH,
            ST_IDLE:           state_len = '0;
            default:           state_len = TMR_W'(PHASE_CLKS - 1);
        endcase
    endfunction

    creg_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    creg_event_counter #(.LIMIT(PREAMBLE_PULSES)) u_pre_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (pre_inc),
        .at_last (pre_last)
    );

    creg_event_counter #(.LIMIT(MAX_POLLS)) u_miss_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (miss_inc),
        .at_last (poll_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_PRE_HI;
            ST_PRE_HI:   if (tmr_done)  state_d = ST_PRE_LO;
            ST_PRE_LO:   if (tmr_done)  state_d = pre_last ? ST_SEL : ST_PRE_HI;
            ST_SEL:      if (tmr_done)  state_d = ST_ADDR;
            ST_ADDR:     if (tmr_done)  state_d = ST_ARM;
            ST_ARM:      if (tmr_done)  state_d = ST_GO_HI;
            ST_GO_HI:    if (tmr_done)  state_d = ST_GO_LO;
            ST_GO_LO:    if (tmr_done)  state_d = ST_POLL;
            ST_POLL:     state_d = port_ack ? ST_FINISH : ST_RETRY_HI;
            ST_RETRY_HI: if (tmr_done)  state_d = ST_RETRY_LO;
            ST_RETRY_LO: if (tmr_done)  state_d = ST_PAUSE;
            ST_PAUSE:    if (tmr_done)  state_d = poll_last ? ST_FINISH : ST_POLL;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = state_len(state_d);

    // State register and request/result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            fail_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                fail_q  <= 1'b0;
            end
            if (miss_inc && poll_last) begin
                fail_q <= 1'b1;
            end
            if ((state_q == ST_POLL) && port_ack && !wr_q) begin
                rdata_q <= port_rdata;
            end
        end
    end

    // Output decode
    always_comb begin
        port_clk   = 1'b0;
        port_sel   = 1'b0;
        drive_addr = 1'b0;
        en_phase   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH:     ;
            ST_PRE_HI:              port_clk = 1'b1;
            ST_PRE_LO:              ;
            ST_SEL:                 port_sel = 1'b1;
            ST_ADDR: begin
                port_sel   = 1'b1;
                drive_addr = 1'b1;
            end
            ST_ARM, ST_GO_LO: begin
                port_sel   = 1'b1;
                drive_addr = 1'b1;
                en_phase   = 1'b1;
            end
            ST_GO_HI: begin
                port_sel   = 1'b1;
                drive_addr = 1'b1;
                en_phase   = 1'b1;
                port_clk   = 1'b1;
            end
            ST_RETRY_HI: begin
                port_sel   = 1'b1;
                drive_addr = 1'b1;
                port_clk   = 1'b1;
            end
            ST_POLL, ST_RETRY_LO, ST_PAUSE: begin
                port_sel   = 1'b1;
                drive_addr = 1'b1;
            end
            default: ;
        endcase
    end

    assign port_rd_en = en_phase && !wr_q;
    assign port_wr_en = en_phase && wr_q;
    assign port_addr  = drive_addr ? addr_q : '0;
    assign port_wdata = (drive_addr && wr_q) ? wdata_q : '0;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FINISH);
    assign timeout    = (state_q == ST_FINISH) && fail_q;
    assign rdata      = rdata_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(port_clk || port_sel || port_rd_en || port_wr_en || done));

    // R5
    en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd_en && port_wr_en));

    // R5
    en_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_en || port_wr_en) |-> port_sel);

    // R4
    wdata_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_wr_en) |-> (port_wdata == $past(port_wdata)) && $past(port_sel));

    // R9
    ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q) && $stable(wr_q));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (done && !timeout));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R7
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
endmodule

// File: tb/phy_creg_master_tb.sv
module phy_creg_master_tb;
    localparam int P   = 2;
    localparam int CPU = 3;
    localparam int WUS = 2;
    localparam int W   = CPU * WUS;
    localparam int PRE = 100;
    localparam int MP  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, timeout;
    logic [15:0] rdata;
    logic        port_clk, port_sel, port_rd_en, port_wr_en;
    logic [15:0] port_addr, port_wdata, port_rdata;
    logic        port_ack;

    always #5 clk = ~clk;

    phy_creg_master #(
        .PHASE_CLKS(P), .PREAMBLE_PULSES(PRE), .MAX_POLLS(MP),
        .CLKS_PER_US(CPU), .POLL_WAIT_US(WUS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .timeout(timeout), .rdata(rdata), .port_clk(port_clk), .port_sel(port_sel),
        .port_rd_en(port_rd_en), .port_wr_en(port_wr_en), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .port_ack(port_ack)
    );

    int checks = 0;
    int fails  = 0;

    // port model state
    int          pulse_total = 0;
    int          poll_pulses = 0;
    int          ack_k = 1;
    bit          started = 1'b0;
    int          pulses_at_sel = -1;
    bit          busy_at_sel = 1'b0;
    logic [15:0] addr_at_sel = '0;
    logic [15:0] addr_at_en = '0;
    logic [15:0] wdata_at_en = '0;
    bit          rd_seen = 1'b0;
    bit          wr_seen = 1'b0;
    bit          both_seen = 1'b0;
    int          hi_run = 0;
    int          last_hi = 0;
    wire         en_any = port_rd_en | port_wr_en;

    assign port_ack   = started && (poll_pulses >= ack_k - 1);
    assign port_rdata = port_addr ^ 16'h5A3C;

    always @(posedge port_clk) begin
        pulse_total++;
        if (started) poll_pulses++;
    end
    always @(posedge port_sel) begin
        pulses_at_sel = pulse_total;
        busy_at_sel   = busy;
        addr_at_sel   = port_addr;
    end
    always @(posedge en_any) begin
        addr_at_en  = port_addr;
        wdata_at_en = port_wdata;
        rd_seen     = port_rd_en;
        wr_seen     = port_wr_en;
        both_seen   = port_rd_en && port_wr_en;
    end
    always @(negedge en_any) started = 1'b1;
    always @(negedge clk) begin
        if (port_clk) hi_run++;
        else if (hi_run > 0) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                             input int k, inout logic [15:0] exp_rdata);
        int n;
        int kk;
        int exp_lat;
        int exp_pulses;
        bit exp_to;
        @(negedge clk);
        pulse_total   = 0;
        poll_pulses   = 0;
        started       = 1'b0;
        pulses_at_sel = -1;
        ack_k         = k;
        req_valid     = 1'b1;
        req_write     = wr;
        req_addr      = a;
        req_wdata     = d;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            req_valid = 1'b0;
            // R9: a competing request while busy must be ignored
            if (n == 40) begin
                req_valid = 1'b1;
                req_write = ~wr;
                req_addr  = ~a;
                req_wdata = ~d;
            end
            if (done || n > 5000) break;
        end
        exp_to     = (k > MP);
        kk         = exp_to ? MP : k;
        exp_lat    = 205 * P + kk + (exp_to ? kk : kk - 1) * (2 * P + W) + 1;
        exp_pulses = PRE + 1 + (exp_to ? MP : k - 1);
        check(pulses_at_sel == PRE, "R2 preamble pulses", pulses_at_sel, PRE);
        check(last_hi == P, "R2 pulse high width", last_hi, P);
        check(addr_at_sel == 16'h0, "R3 address zero at select", addr_at_sel, 0);
        check(addr_at_en == a, "R3/R9 address at enable", addr_at_en, a);
        check(busy_at_sel, "R9 busy during access", busy_at_sel, 1);
        check(rd_seen == !wr && wr_seen == wr && !both_seen, "R5 enable kind",
              {rd_seen, wr_seen, both_seen}, {!wr, wr, 1'b0});
        if (wr) check(wdata_at_en == d, "R4 write data at enable", wdata_at_en, d);
        check(n == exp_lat, "R6 latency to done", n, exp_lat);
        check(pulse_total == exp_pulses, "R6 total port pulses", pulse_total, exp_pulses);
        check(timeout == exp_to, "R7 timeout flag", timeout, exp_to);
        if (!wr && !exp_to) exp_rdata = a ^ 16'h5A3C;
        check(rdata == exp_rdata, exp_to ? "R7 rdata kept" : "R8 rdata", rdata, exp_rdata);
        req_valid = 1'b0;
        @(negedge clk);
        check(!done && !busy, "R10 done single pulse", {done, busy}, 0);
    endtask

    initial begin
        logic [15:0] exp_rd;
        exp_rd = '0;
        repeat (3) @(negedge clk);
        check(!port_clk && !port_sel && !port_rd_en && !port_wr_en && !busy && !done,
              "R1 outputs during reset",
              {port_clk, port_sel, port_rd_en, port_wr_en, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !timeout && port_addr == 0 && port_wdata == 0 && rdata == 0,
              "R1 idle after reset", {busy, timeout}, 0);
        for (int k = 1; k <= MP + 1; k++) begin
            do_access(1'b0, 16'h1000 + 16'(k * 37), 16'h0, k, exp_rd);
            do_access(1'b1, 16'h2F00 + 16'(k * 11), 16'hC000 | 16'(k), k, exp_rd);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule